// File: doc/BRIEF.md
# Pop-Free Channel Mute and Gain Ramp Controller

This block sequences one amplifier channel between three resting conditions: output high-impedance with switching stopped, switching with zero gain (muted), and full playback. It never steps the output abruptly on a normal request. Switching begins or ends under a common-mode level ramp. Moving between muted and playing goes through a gain ramp. Both ramps advance one step per pulse of a free-running timebase tick. The step indices drive the analog common-mode and gain networks, which lie outside this block.

Two requests drive the channel. `run_req` keeps switching on, and `play_req` asks for audible output. A protection fault or a low `standby_n` bypasses both ramps and drops the channel straight to high impedance. After a fault, the channel is held off until the fault has cleared and a fresh play request is seen. The target gain, one of four settings, is captured at the moment the gain ramp starts.

Top module: `chan_pop_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `mod_en` is 0, `cm_step` and `gain_step` are 0, and `gain_code` is 0.
- R2: From high impedance, with `standby_n` high, no fault and no lockout, `run_req` high at an edge sets `mod_en` to 1 at that edge. `cm_step` then rises by one at each later edge where `tick` is high, up to CM_STEPS. At the edge after it reaches CM_STEPS, the channel is muted and `gain_step` has stayed 0 throughout.
- R3: While muted, `run_req` and `play_req` high start the gain ramp at the next edge. `gain_step` then rises by one per ticked edge up to GAIN_STEPS and holds there in play. `gain_step` is non-zero only while `cm_step` equals CM_STEPS.
- R4: `gain_sel` encodes 0=12 dB, 1=20 dB, 2=26 dB, 3=32 dB. It is copied to `gain_code` at the edge that moves a muted channel into its gain ramp. `gain_code` then holds while `gain_step` is non-zero.
- R5: Dropping `play_req` during the up-ramp or in play lowers `gain_step` by one per ticked edge to 0. The channel then rests muted with `mod_en` still 1.
- R6: Dropping `run_req` first takes the gain down as in R5. It then lowers `cm_step` by one per ticked edge to 0. At the edge after `cm_step` is 0, `mod_en` falls to 0.
- R7: If the request returns during a ramp-down (`play_req` and `run_req` for gain, `run_req` for common mode), the same index turns upward from its current value without going back to 0.
- R8: `fault` high at an edge gives `mod_en`, `cm_step` and `gain_step` all 0 from that edge on, with no ramp.
- R9: After a fault, the channel stays in high impedance until an edge where `fault` is low and `play_req` is high having been low at the previous edge. The channel may leave high impedance from the edge after that.
- R10: `standby_n` low at an edge forces the same immediate high impedance as R8, but sets no lockout.
- R11: A step index changes by at most one per edge, changes only at edges where `tick` is high (except the forced clear of R8/R10), and never exceeds its step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_n | input | 1 | Low forces immediate high impedance |
| run_req | input | 1 | Keep switching on (muted or playing) |
| play_req | input | 1 | Request audible play |
| gain_sel | input | 2 | Target gain: 0=12 dB, 1=20 dB, 2=26 dB, 3=32 dB |
| fault | input | 1 | Any protection fault, active high |
| tick | input | 1 | Ramp timebase pulse, one clock wide |
| mod_en | output | 1 | Modulator switching enable |
| cm_step | output | CW | Common-mode ramp index, 0..CM_STEPS |
| gain_step | output | GW | Gain ramp index, 0..GAIN_STEPS |
| gain_code | output | 2 | Gain setting applied during the current gain ramp |

## Verification
A wrong sequencer state shows at the ports within one clock edge. A stuck or skipped state either leaves a step index frozen while `tick` pulses, or moves an index without a tick. An out-of-order state produces a non-zero `gain_step` while `cm_step` is short of full, or a non-zero index while `mod_en` is low. A lost fault lockout shows as `mod_en` rising before a fresh play request. A stale latched gain shows as `gain_code` changing mid-ramp. The bench follows a cycle-level model of the requirements and compares all outputs after every edge, so any divergence is reported at the cycle it appears.

// File: rtl/chan_pop_pkg.sv
// Shared types for the channel pop-free controller.
// Assumes nothing beyond a single clock domain.
package chan_pop_pkg;

    typedef enum logic [2:0] {
        ST_HIZ   = 3'd0,
        ST_CM_UP = 3'd1,
        ST_MUTE  = 3'd2,
        ST_G_UP  = 3'd3,
        ST_PLAY  = 3'd4,
        ST_G_DN  = 3'd5,
        ST_CM_DN = 3'd6
    } chan_state_t;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DN   = 2'd2
    } ramp_cmd_t;

endpackage

// File: rtl/chan_ramp_ctr.sv
// Saturating up/down step counter for one ramp.
// Moves one step per tick in the commanded direction, clears at once on
// clear. Assumes tick is a single-cycle pulse.
module chan_ramp_ctr
    import chan_pop_pkg::*;
#(
    parameter int STEPS = 16,
    localparam int W = $clog2(STEPS + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  ramp_cmd_t cmd,
    input  logic      tick,
    output logic [W-1:0] step,
    output logic      at_top,
    output logic      at_bot
);
    localparam logic [W-1:0] TOP = W'(STEPS);

    // Step register: clear, then saturating move on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            step <= '0;
        end else if (tick) begin
            if (cmd == RAMP_UP && step != TOP) begin
                step <= step + W'(1);
            end else if (cmd == RAMP_DN && step != '0) begin
                step <= step - W'(1);
            end
        end
    end

    // End-of-range flags for the sequencer.
    always_comb begin
        at_top = (step == TOP);
        at_bot = (step == '0);
    end

    p_unit_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear) |=> ((int'(step) - int'($past(step))) inside {-1, 0, 1}));

    p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(step));

    p_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        step <= TOP);

endmodule

// File: rtl/chan_fault_guard.sv
// Fault lockout: set by any fault, released only by a fresh play request
// (play_req rising) seen while the fault input is low.
module chan_fault_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic play_req,
    output logic lock
);
    logic play_q;

    // Remember last play request to detect a fresh one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_q <= 1'b0;
        end else begin
            play_q <= play_req;
        end
    end

    // Lock flag: set on fault, clear on clean rising play request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
        end else if (fault) begin
            lock <= 1'b1;
        end else if (play_req && !play_q) begin
            lock <= 1'b0;
        end
    end

    p_fault_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> lock);

    p_stale_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !(play_req && !play_q)) |=> lock);

endmodule

// File: rtl/chan_seq_fsm.sv
// Channel sequencer: Hi-Z -> CM ramp up -> mute -> gain ramp up -> play,
// and the reverse. Ramp-downs reverse in place when the request returns.
// Fault or standby low skip all ramps. Assumes ramp counters report
// their end flags from registered step values.
module chan_seq_fsm
    import chan_pop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby_n,
    input  logic        fault,
    input  logic        run_req,
    input  logic        play_req,
    input  logic        lock,
    input  logic        cm_top,
    input  logic        cm_bot,
    input  logic        g_top,
    input  logic        g_bot,
    output chan_state_t state,
    output ramp_cmd_t   cm_cmd,
    output ramp_cmd_t   g_cmd,
    output logic        kill,
    output logic        load_code
);
    chan_state_t nxt;
    logic        want_play;

    // Request decode and forced-off condition.
    always_comb begin
        kill      = fault || !standby_n;
        want_play = run_req && play_req;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (kill) begin
            nxt = ST_HIZ;
        end else begin
            unique case (state)
                ST_HIZ:   if (run_req && !lock) nxt = ST_CM_UP;
                ST_CM_UP: if (!run_req) nxt = ST_CM_DN;
                          else if (cm_top) nxt = ST_MUTE;
                ST_MUTE:  if (!run_req) nxt = ST_CM_DN;
                          else if (play_req) nxt = ST_G_UP;
                ST_G_UP:  if (!want_play) nxt = ST_G_DN;
                          else if (g_top) nxt = ST_PLAY;
                ST_PLAY:  if (!want_play) nxt = ST_G_DN;
                ST_G_DN:  if (want_play) nxt = ST_G_UP;
                          else if (g_bot) nxt = ST_MUTE;
                ST_CM_DN: if (run_req) nxt = ST_CM_UP;
                          else if (cm_bot) nxt = ST_HIZ;
                default:  nxt = ST_HIZ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HIZ;
        end else begin
            state <= nxt;
        end
    end

    // Ramp commands follow the present state.
    always_comb begin
        cm_cmd = (state == ST_CM_UP) ? RAMP_UP :
                 (state == ST_CM_DN) ? RAMP_DN : RAMP_HOLD;
        g_cmd  = (state == ST_G_UP)  ? RAMP_UP :
                 (state == ST_G_DN)  ? RAMP_DN : RAMP_HOLD;
        load_code = (state == ST_MUTE) && (nxt == ST_G_UP);
    end

    p_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIZ && !kill) |=> (state == ST_HIZ || state == ST_CM_UP));

    p_play_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY) |-> g_top);

    p_mute_at_full_cm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTE) |-> (cm_top && g_bot));

endmodule

// File: rtl/chan_pop_ctrl.sv
// Top: per-channel pop-free Hi-Z / mute / play controller.
// Produces modulator enable plus common-mode and gain step indices.
// Assumes tick comes from a free-running timebase in the same clock domain.
module chan_pop_ctrl
    import chan_pop_pkg::*;
#(
    parameter int CM_STEPS   = 16,
    parameter int GAIN_STEPS = 16,
    localparam int CW = $clog2(CM_STEPS + 1),
    localparam int GW = $clog2(GAIN_STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_n,
    input  logic          run_req,
    input  logic          play_req,
    input  logic [1:0]    gain_sel,
    input  logic          fault,
    input  logic          tick,
    output logic          mod_en,
    output logic [CW-1:0] cm_step,
    output logic [GW-1:0] gain_step,
    output logic [1:0]    gain_code
);
    localparam logic [CW-1:0] CM_TOP = CW'(CM_STEPS);

    chan_state_t state;
    ramp_cmd_t   cm_cmd;
    ramp_cmd_t   g_cmd;
    logic        kill, load_code, lock;
    logic        cm_top, cm_bot, g_top, g_bot;

    chan_fault_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault),
        .play_req (play_req),
        .lock     (lock)
    );

    chan_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_n (standby_n),
        .fault     (fault),
        .run_req   (run_req),
        .play_req  (play_req),
        .lock      (lock),
        .cm_top    (cm_top),
        .cm_bot    (cm_bot),
        .g_top     (g_top),
        .g_bot     (g_bot),
        .state     (state),
        .cm_cmd    (cm_cmd),
        .g_cmd     (g_cmd),
        .kill      (kill),
        .load_code (load_code)
    );

    chan_ramp_ctr #(.STEPS(CM_STEPS)) u_cm_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (kill),
        .cmd    (cm_cmd),
        .tick   (tick),
        .step   (cm_step),
        .at_top (cm_top),
        .at_bot (cm_bot)
    );

    chan_ramp_ctr #(.STEPS(GAIN_STEPS)) u_g_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (kill),
        .cmd    (g_cmd),
        .tick   (tick),
        .step   (gain_step),
        .at_top (g_top),
        .at_bot (g_bot)
    );

    // Gain setting captured when a gain ramp starts from mute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= 2'd0;
        end else if (load_code) begin
            gain_code <= gain_sel;
        end
    end

    // Switching runs in every state except Hi-Z.
    always_comb begin
        mod_en = (state != ST_HIZ);
    end

    p_hiz_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> (cm_step == '0 && gain_step == '0));

    p_gain_needs_cm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_step != '0) |-> (cm_step == CM_TOP));

    p_code_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_step != '0 && !load_code) |=> $stable(gain_code));

    p_fault_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!mod_en && cm_step == '0 && gain_step == '0));

    p_standby_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> !mod_en);

    p_locked_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !mod_en);

endmodule

// File: tb/tb_chan_pop_ctrl.sv
// Self-checking bench: directed sequences plus seeded random stimulus,
// compared each cycle against a cycle-level reference of the requirements.
module tb_chan_pop_ctrl;
    localparam int CMS = 16;
    localparam int GS  = 16;
    localparam int CW  = $clog2(CMS + 1);
    localparam int GW  = $clog2(GS + 1);

    localparam int M_HIZ = 0, M_CMU = 1, M_MUTE = 2, M_GU = 3,
                   M_PLAY = 4, M_GD = 5, M_CMD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_n = 1'b1, run_req = 1'b0, play_req = 1'b0;
    logic fault = 1'b0, tick = 1'b0;
    logic [1:0] gain_sel = 2'd0;
    logic mod_en;
    logic [CW-1:0] cm_step;
    logic [GW-1:0] gain_step;
    logic [1:0] gain_code;

    int errors = 0;
    int checks = 0;
    bit checking = 0;
    bit done = 0;

    // reference model state
    int m_st = M_HIZ, m_cm = 0, m_g = 0, m_code = 0;
    bit m_lock = 0, m_pq = 0;
    string m_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    chan_pop_ctrl #(.CM_STEPS(CMS), .GAIN_STEPS(GS)) dut (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .run_req(run_req),
        .play_req(play_req), .gain_sel(gain_sel), .fault(fault), .tick(tick),
        .mod_en(mod_en), .cm_step(cm_step), .gain_step(gain_step),
        .gain_code(gain_code)
    );

    // Reference update at each edge, from the requirements.
    always @(posedge clk) begin
        int ns, ncm, ng;
        bit nlock, wp;
        if (!rst_n) begin
            m_st = M_HIZ; m_cm = 0; m_g = 0; m_code = 0; m_lock = 0; m_pq = 0;
            m_tag = "R1";
        end else begin
            wp = run_req && play_req;
            nlock = fault ? 1'b1 : ((play_req && !m_pq) ? 1'b0 : m_lock);
            ns = m_st; ncm = m_cm; ng = m_g;
            if (fault || !standby_n) begin
                ns = M_HIZ; ncm = 0; ng = 0;
                m_tag = fault ? "R8" : "R10";
            end else begin
                m_tag = tick ? "R2" : "R11";
                if (tick) begin
                    if (m_st == M_CMU && m_cm < CMS) ncm = m_cm + 1;
                    if (m_st == M_CMD && m_cm > 0)   ncm = m_cm - 1;
                    if (m_st == M_GU && m_g < GS)    ng = m_g + 1;
                    if (m_st == M_GD && m_g > 0)     ng = m_g - 1;
                end
                case (m_st)
                    M_HIZ: begin
                        if (m_lock) m_tag = "R9";
                        if (run_req && !m_lock) ns = M_CMU;
                    end
                    M_CMU: if (!run_req) ns = M_CMD; else if (m_cm == CMS) ns = M_MUTE;
                    M_MUTE: begin
                        m_tag = "R3";
                        if (!run_req) ns = M_CMD;
                        else if (play_req) begin ns = M_GU; m_code = gain_sel; end
                    end
                    M_GU: begin
                        m_tag = "R3";
                        if (!wp) ns = M_GD; else if (m_g == GS) ns = M_PLAY;
                    end
                    M_PLAY: begin
                        m_tag = "R3";
                        if (!wp) ns = M_GD;
                    end
                    M_GD: begin
                        m_tag = "R5";
                        if (wp) begin ns = M_GU; m_tag = "R7"; end
                        else if (m_g == 0) ns = M_MUTE;
                    end
                    M_CMD: begin
                        m_tag = "R6";
                        if (run_req) begin ns = M_CMU; m_tag = "R7"; end
                        else if (m_cm == 0) ns = M_HIZ;
                    end
                    default: ns = M_HIZ;
                endcase
            end
            m_st = ns; m_cm = ncm; m_g = ng; m_lock = nlock; m_pq = play_req;
        end
    end

    // Compare outputs to the reference between edges.
    always @(negedge clk) begin
        if (checking && !done) begin
            bit exp_en;
            exp_en = (m_st != M_HIZ);
            checks++;
            if (mod_en !== exp_en || int'(cm_step) != m_cm || int'(gain_step) != m_g) begin
                errors++;
                $display("FAIL %s: en/cm/gain got %b/%0d/%0d expected %b/%0d/%0d at %0t",
                         m_tag, mod_en, cm_step, gain_step, exp_en, m_cm, m_g, $time);
            end
            checks++;
            if (int'(gain_code) != m_code) begin
                errors++;
                $display("FAIL R4: gain_code got %0d expected %0d at %0t",
                         gain_code, m_code, $time);
            end
        end
    end

    task automatic drive(input bit en, input bit pl, input bit sb,
                         input bit flt, input bit tk, input logic [1:0] gs);
        @(negedge clk);
        run_req = en; play_req = pl; standby_n = sb; fault = flt; tick = tk;
        gain_sel = gs;
    endtask

    task automatic run_for(input int n, input bit en, input bit pl,
                           input logic [1:0] gs);
        for (int i = 0; i < n; i++) drive(en, pl, 1'b1, 1'b0, (i % 3) == 0, gs);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, checked directly
        checks++;
        if (mod_en !== 1'b0 || cm_step != '0 || gain_step != '0 || gain_code != 2'd0) begin
            errors++;
            $display("FAIL R1: got en=%b cm=%0d g=%0d code=%0d expected 0/0/0/0",
                     mod_en, cm_step, gain_step, gain_code);
        end
        checking = 1;
        // R2/R11: power-up, including a stretch with no ticks
        run_for(10, 1'b1, 1'b0, 2'd2);
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
        run_for(60, 1'b1, 1'b0, 2'd2);
        // R3/R4: play with 26 dB
        run_for(60, 1'b1, 1'b1, 2'd2);
        // R5 then R7: mute part way, then resume
        run_for(20, 1'b1, 1'b0, 2'd3);
        run_for(60, 1'b1, 1'b1, 2'd3);
        run_for(60, 1'b1, 1'b0, 2'd1);
        // R6 then R7: power down part way, then resume
        run_for(20, 1'b0, 1'b0, 2'd1);
        run_for(60, 1'b1, 1'b1, 2'd0);
        // R8/R9: fault in play, then play held high stays locked
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
        run_for(20, 1'b1, 1'b1, 2'd0);
        run_for(3, 1'b1, 1'b0, 2'd0);
        run_for(120, 1'b1, 1'b1, 2'd1);
        // R10: standby low during play, no lockout
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1);
        run_for(120, 1'b1, 1'b1, 2'd1);
        // Random phase
        begin
            bit en = 1, pl = 1;
            logic [1:0] gs = 2'd0;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom_range(0, 63) == 0) en = ~en;
                if ($urandom_range(0, 31) == 0) begin pl = ~pl; gs = 2'($urandom_range(0, 3)); end
                drive(en, pl, ($urandom_range(0, 799) != 0),
                      ($urandom_range(0, 499) == 0), $urandom_range(0, 1) == 1, gs);
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule